// File: doc/BRIEF.md
# Debug Serial Block Loader

This block sits between an external debug probe and the on-chip memory write path. The probe clocks fixed-length frames into it over a one-bit serial link. Each frame carries a type and a 32-bit payload. Once the loader has been armed, every data frame becomes one memory store. The probe sends no per-word instructions, so a block transfer costs one frame per word.

The probe first sends a data frame while the loader is idle. That frame sets the destination pointer to the first target address minus one word step. A start command then arms the loader. From then on, each data frame stores its payload at the pointer plus the step, and the pointer moves to that address. To finish, the probe sends an end command followed by one throw-away data frame. That frame is consumed without a store and returns the loader to idle.

Every frame returns a two-bit status on the serial output. The status tells the probe whether the previous frame was taken, rejected for bad sequencing, discarded because the core had an interrupt pending, or carried no data.

Top module: `dbg_block_loader`

## Requirements
- R1: After a synchronous active-low reset, no store is requested, the loader is idle, and the first status returned is 2'b11 (null).
- R2: A frame is 35 strobes long. The first two bits are the type, shifted MSB first (00 instruction, 01 data, 10 command, 11 reserved). The next 32 bits are the payload, shifted MSB first. The last bit is parity and has no effect.
- R3: While the first two bits of a frame are shifted in, the serial output presents the status of the previous frame, MSB first, and drives 0 on all other strobes. The status codes are 00 accepted data, 01 sequencing error, 10 interrupt occurred and 11 null.
- R4: A data frame received while idle loads the pointer with its payload, returns status 00, and requests no store.
- R5: A command payload of 1 arms an idle loader. While armed, each data frame requests a store of its payload at the pointer plus 4, the pointer then takes that address, and the status is 00.
- R6: A store request stays asserted, with address and data unchanged, until ready is seen high.
- R7: A data frame that completes while a store request is still outstanding is dropped and returns status 01.
- R8: A command payload of 2 received while armed moves the loader to ending. The next data frame is discarded without a store, returns status 00 and puts the loader back to idle, so the following data frame reloads the pointer.
- R9: If the interrupt input is high when a frame completes, the frame has no effect and the status is 10.
- R10: After a status of 01 or 10, data frames are rejected with status 01 and have no effect until an instruction or command frame arrives.
- R11: Instruction, command and reserved frames return status 11. A command payload other than 1 or 2 leaves the loader's mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_sen | input | 1 | Serial strobe; one bit is taken per cycle it is high |
| dbg_sdi | input | 1 | Serial data from the probe |
| dbg_sdo | output | 1 | Serial status to the probe |
| irq_pend | input | 1 | Core has an interrupt pending |
| mem_valid | output | 1 | Store request |
| mem_ready | input | 1 | Memory accepts the store |
| mem_addr | output | 32 | Store address |
| mem_data | output | 32 | Store data |

## Verification
The loader is driven through a full block transfer whose words have alternating parity bits. This confirms that stores land at consecutive word addresses and that parity has no effect. Two closing sequences check that the throw-away word is dropped and that a later idle data frame reloads the pointer. A held-off ready exposes the difference between stalling a store and dropping a word that arrives behind it. Interrupt, sequencing-error, unknown-command and reserved-type frames are mixed into an armed transfer, and the stored addresses afterwards show whether any of these frames moved the pointer or the mode.

// File: rtl/dbg_loader_pkg.sv
// Package: shared encodings for the debug block loader.
// Assumes 2-bit type and status fields as listed in the requirements.
package dbg_loader_pkg;
    typedef enum logic [1:0] {
        FT_INSN = 2'b00,
        FT_DATA = 2'b01,
        FT_CMD  = 2'b10,
        FT_RSVD = 2'b11
    } frame_kind_e;

    typedef enum logic [1:0] {
        RS_OK     = 2'b00,
        RS_SEQERR = 2'b01,
        RS_INT    = 2'b10,
        RS_NULL   = 2'b11
    } reply_e;

    typedef enum logic [1:0] {
        LM_IDLE   = 2'b00,
        LM_ARMED  = 2'b01,
        LM_ENDING = 2'b10
    } load_mode_e;
endpackage

// File: rtl/dbg_frame_rx.sv
// Frame receiver: collects 2 + PAY_W + 1 serial bits per frame.
// Pulses frm_vld for one cycle with the type and payload; the parity bit
// is counted but never stored. Drives the reply of the previous frame
// onto sdo during the first two strobes. Assumes the strobe is already
// synchronous to clk.
module dbg_frame_rx
    import dbg_loader_pkg::*;
#(
    parameter int PAY_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sen,
    input  logic              sdi,
    input  reply_e            reply,
    output logic              sdo,
    output logic              frm_vld,
    output frame_kind_e       frm_kind,
    output logic [PAY_W-1:0]  frm_pay
);
    localparam int FRAME_W = PAY_W + 3;
    localparam int BODY_W  = PAY_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W);

    logic [BODY_W-1:0] body;
    logic [CNT_W-1:0]  bit_cnt;

    // Shift in body bits, count strobes, publish the frame on the parity strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            body     <= '0;
            bit_cnt  <= '0;
            frm_vld  <= 1'b0;
            frm_kind <= FT_INSN;
            frm_pay  <= '0;
        end else begin
            frm_vld <= 1'b0;
            if (sen) begin
                if (bit_cnt == CNT_W'(FRAME_W - 1)) begin
                    bit_cnt  <= '0;
                    frm_vld  <= 1'b1;
                    frm_kind <= frame_kind_e'(body[BODY_W-1 -: 2]);
                    frm_pay  <= body[PAY_W-1:0];
                end else begin
                    body    <= {body[BODY_W-2:0], sdi};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // Reply bits go out MSB first on the first two strobes of a frame.
    always_comb begin
        if (bit_cnt == '0)
            sdo = reply[1];
        else if (bit_cnt == CNT_W'(1))
            sdo = reply[0];
        else
            sdo = 1'b0;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt < CNT_W'(FRAME_W)); // R2
    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |=> !frm_vld); // R2
endmodule

// File: rtl/dbg_load_ctrl.sv
// Loader control: mode machine, destination pointer, reply code and the
// must-restart flag. Acts once per completed frame and asks the store
// port for a write through wr_issue. Assumes PAY_W-wide data and ADDR_W
// not wider than PAY_W.
module dbg_load_ctrl
    import dbg_loader_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PAY_W  = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_vld,
    input  frame_kind_e       frm_kind,
    input  logic [PAY_W-1:0]  frm_pay,
    input  logic              irq_pend,
    input  logic              wr_busy,
    output logic              wr_issue,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PAY_W-1:0]  wr_data,
    output reply_e            reply
);
    localparam logic [PAY_W-1:0] CMD_BEGIN = PAY_W'(1);
    localparam logic [PAY_W-1:0] CMD_CLOSE = PAY_W'(2);

    load_mode_e        mode;
    logic [ADDR_W-1:0] ptr;
    logic              restart_req;
    logic [ADDR_W-1:0] next_addr;
    logic              take_data;

    assign next_addr = ptr + ADDR_W'(STEP);
    assign take_data = frm_vld && !irq_pend && (frm_kind == FT_DATA) && !restart_req;

    // Store request for an armed data frame when the port is free.
    always_comb begin
        wr_issue = take_data && (mode == LM_ARMED) && !wr_busy;
        wr_addr  = next_addr;
        wr_data  = frm_pay;
    end

    // Per-frame update of mode, pointer, reply and restart flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode        <= LM_IDLE;
            ptr         <= '0;
            restart_req <= 1'b0;
            reply       <= RS_NULL;
        end else if (frm_vld) begin
            if (irq_pend) begin
                reply       <= RS_INT;
                restart_req <= 1'b1;
            end else begin
                case (frm_kind)
                    FT_DATA: begin
                        if (restart_req) begin
                            reply <= RS_SEQERR;
                        end else begin
                            case (mode)
                                LM_IDLE: begin
                                    ptr   <= ADDR_W'(frm_pay);
                                    reply <= RS_OK;
                                end
                                LM_ARMED: begin
                                    if (wr_busy) begin
                                        reply       <= RS_SEQERR;
                                        restart_req <= 1'b1;
                                    end else begin
                                        ptr   <= next_addr;
                                        reply <= RS_OK;
                                    end
                                end
                                default: begin
                                    mode  <= LM_IDLE;
                                    reply <= RS_OK;
                                end
                            endcase
                        end
                    end
                    FT_CMD: begin
                        restart_req <= 1'b0;
                        reply       <= RS_NULL;
                        if (frm_pay == CMD_BEGIN && mode == LM_IDLE)
                            mode <= LM_ARMED;
                        else if (frm_pay == CMD_CLOSE && mode == LM_ARMED)
                            mode <= LM_ENDING;
                    end
                    FT_INSN: begin
                        restart_req <= 1'b0;
                        reply       <= RS_NULL;
                    end
                    default: reply <= RS_NULL;
                endcase
            end
        end
    end

    AST_INT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && irq_pend) |-> !wr_issue); // R9
    AST_INT_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && irq_pend) |=> (reply == RS_INT)); // R9
    AST_PTR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_vld |=> $stable(ptr)); // R5
    AST_RESTART_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && restart_req && frm_kind == FT_DATA) |-> !wr_issue); // R10
    AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != LM_ARMED) |-> !wr_issue); // R4
endmodule

// File: rtl/dbg_store_port.sv
// Store port: holds one write request until the memory accepts it.
// Assumes the controller issues only while busy is low.
module dbg_store_port #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              mem_ready,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              busy
);
    // Capture a new request, or retire the held one on ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
            mem_addr  <= '0;
            mem_data  <= '0;
        end else if (issue) begin
            mem_valid <= 1'b1;
            mem_addr  <= addr_in;
            mem_data  <= data_in;
        end else if (mem_valid && mem_ready) begin
            mem_valid <= 1'b0;
        end
    end

    assign busy = mem_valid;

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R6
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !mem_valid); // R7
endmodule

// File: rtl/dbg_block_loader.sv
// Top: serial debug frames in, word stores out. Wires the frame
// receiver, loader control and store port. Assumes the serial strobe is
// synchronous to clk.
module dbg_block_loader
    import dbg_loader_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PAY_W  = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_sen,
    input  logic              dbg_sdi,
    output logic              dbg_sdo,
    input  logic              irq_pend,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PAY_W-1:0]  mem_data
);
    reply_e            reply;
    logic              frm_vld;
    frame_kind_e       frm_kind;
    logic [PAY_W-1:0]  frm_pay;
    logic              wr_issue;
    logic              wr_busy;
    logic [ADDR_W-1:0] wr_addr;
    logic [PAY_W-1:0]  wr_data;

    dbg_frame_rx #(.PAY_W(PAY_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sen      (dbg_sen),
        .sdi      (dbg_sdi),
        .reply    (reply),
        .sdo      (dbg_sdo),
        .frm_vld  (frm_vld),
        .frm_kind (frm_kind),
        .frm_pay  (frm_pay)
    );

    dbg_load_ctrl #(.ADDR_W(ADDR_W), .PAY_W(PAY_W), .STEP(STEP)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_vld  (frm_vld),
        .frm_kind (frm_kind),
        .frm_pay  (frm_pay),
        .irq_pend (irq_pend),
        .wr_busy  (wr_busy),
        .wr_issue (wr_issue),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .reply    (reply)
    );

    dbg_store_port #(.ADDR_W(ADDR_W), .DATA_W(PAY_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (wr_issue),
        .addr_in   (wr_addr),
        .data_in   (wr_data),
        .mem_ready (mem_ready),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .busy      (wr_busy)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !mem_valid); // R1
endmodule

// File: tb/dbg_block_loader_test.sv
`timescale 1ns/1ps
module dbg_block_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_sen = 1'b0;
    logic        dbg_sdi = 1'b0;
    logic        dbg_sdo;
    logic        irq_pend = 1'b0;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;

    int n_chk = 0;
    int n_bad = 0;
    int wr_n = 0;
    logic [31:0] log_addr [16];
    logic [31:0] log_data [16];

    localparam logic [1:0] K_INSN = 2'b00, K_DATA = 2'b01, K_CMD = 2'b10, K_RSVD = 2'b11;

    always #4 clk = ~clk;

    dbg_block_loader uut (
        .clk(clk), .rst_n(rst_n), .dbg_sen(dbg_sen), .dbg_sdi(dbg_sdi),
        .dbg_sdo(dbg_sdo), .irq_pend(irq_pend), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    // Log every accepted store.
    always @(negedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            if (wr_n < 16) begin
                log_addr[wr_n] = mem_addr;
                log_data[wr_n] = mem_data;
            end
            wr_n++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Shift one frame; return the reply seen on the first two strobes.
    task automatic xfer(input logic [1:0] kind, input logic [31:0] pay,
                        input logic par, output logic [1:0] st);
        logic [34:0] fr;
        fr = {kind, pay, par};
        st = 2'b00;
        for (int i = 34; i >= 0; i--) begin
            @(negedge clk);
            if (i == 34) st[1] = dbg_sdo;
            if (i == 33) st[0] = dbg_sdo;
            dbg_sdi = fr[i];
            dbg_sen = 1'b1;
            @(negedge clk);
            dbg_sen = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic check_store(input string req, input int idx,
                               input logic [31:0] a, input logic [31:0] d);
        check(wr_n == idx + 1, req, "store count", wr_n, idx + 1);
        if (wr_n == idx + 1) begin
            check(log_addr[idx] == a, req, "store addr", log_addr[idx], a);
            check(log_data[idx] == d, req, "store data", log_data[idx], d);
        end
    endtask

    task automatic t_reset();
        logic [1:0] st;
        check(mem_valid == 1'b0, "R1", "valid after reset", mem_valid, 0);
        check(dbg_sdo == 1'b1, "R3", "sdo msb of null", dbg_sdo, 1);
        xfer(K_INSN, 32'h0, 1'b0, st);
        check(st == 2'b11, "R1", "first reply null", st, 2'b11);
    endtask

    task automatic t_load();
        logic [1:0] st;
        xfer(K_DATA, 32'h0000_0FFC, 1'b1, st);
        check(st == 2'b11, "R11", "insn reply", st, 2'b11);
        check(wr_n == 0, "R4", "no store when idle", wr_n, 0);
        xfer(K_CMD, 32'h1, 1'b0, st);
        check(st == 2'b00, "R4", "idle data reply", st, 2'b00);
    endtask

    task automatic t_download();
        logic [1:0] st;
        logic [31:0] d;
        for (int k = 0; k < 3; k++) begin
            d = 32'hA5C3_0000 + 32'(k * 32'h1111);
            xfer(K_DATA, d, k[0], st);
            if (k == 0) check(st == 2'b11, "R11", "start cmd reply", st, 2'b11);
            else        check(st == 2'b00, "R5", "data reply", st, 2'b00);
            check_store("R5", k, 32'h1000 + 32'(4 * k), d); // parity varies: R2
        end
        xfer(K_CMD, 32'h2, 1'b1, st);
        check(st == 2'b00, "R2", "last data reply", st, 2'b00);
    endtask

    task automatic t_end();
        logic [1:0] st;
        xfer(K_DATA, 32'hDEAD_BEEF, 1'b0, st);
        check(st == 2'b11, "R11", "end cmd reply", st, 2'b11);
        check(wr_n == 3, "R8", "dummy not stored", wr_n, 3);
        xfer(K_DATA, 32'h0000_1FFC, 1'b0, st);
        check(st == 2'b00, "R8", "dummy reply", st, 2'b00);
        check(wr_n == 3, "R8", "reload not stored", wr_n, 3);
        xfer(K_CMD, 32'h1, 1'b0, st);
        xfer(K_DATA, 32'h1234_5678, 1'b0, st);
        check_store("R8", 3, 32'h2000, 32'h1234_5678);
    endtask

    task automatic t_irq();
        logic [1:0] st;
        irq_pend = 1'b1;
        xfer(K_DATA, 32'h5555_5555, 1'b0, st);
        irq_pend = 1'b0;
        check(wr_n == 4, "R9", "no store on irq", wr_n, 4);
        xfer(K_DATA, 32'h6666_6666, 1'b0, st);
        check(st == 2'b10, "R9", "irq reply", st, 2'b10);
        check(wr_n == 4, "R10", "data after irq dropped", wr_n, 4);
        xfer(K_INSN, 32'h0, 1'b0, st);
        check(st == 2'b01, "R10", "seqerr after irq", st, 2'b01);
        xfer(K_DATA, 32'h7777_7777, 1'b1, st);
        check(st == 2'b11, "R11", "insn reply", st, 2'b11);
        check_store("R10", 4, 32'h2004, 32'h7777_7777);
    endtask

    task automatic t_busy();
        logic [1:0] st;
        mem_ready = 1'b0;
        xfer(K_DATA, 32'h8888_8888, 1'b0, st);
        check(mem_valid == 1'b1, "R6", "request held", mem_valid, 1);
        check(mem_addr == 32'h2008, "R6", "held addr", mem_addr, 32'h2008);
        xfer(K_DATA, 32'h9999_9999, 1'b0, st);
        check(mem_addr == 32'h2008 && mem_data == 32'h8888_8888, "R6", "addr stable",
              mem_addr, 32'h2008);
        mem_ready = 1'b1;
        repeat (3) @(negedge clk);
        check_store("R6", 5, 32'h2008, 32'h8888_8888);
        xfer(K_DATA, 32'hAAAA_AAAA, 1'b0, st);
        check(st == 2'b01, "R7", "busy seqerr", st, 2'b01);
        check(wr_n == 6, "R10", "data after seqerr dropped", wr_n, 6);
        xfer(K_CMD, 32'h7, 1'b0, st);
        check(st == 2'b01, "R10", "still seqerr", st, 2'b01);
        xfer(K_RSVD, 32'h0, 1'b0, st);
        check(st == 2'b11, "R11", "unknown cmd reply", st, 2'b11);
        xfer(K_DATA, 32'hBBBB_BBBB, 1'b0, st);
        check(st == 2'b11, "R11", "reserved reply", st, 2'b11);
        check_store("R11", 6, 32'h200C, 32'hBBBB_BBBB);
        xfer(K_INSN, 32'h0, 1'b0, st);
        check(st == 2'b00, "R3", "data reply code", st, 2'b00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_load();
        t_download();
        t_end();
        t_irq();
        t_busy();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule